// File: doc/BRIEF.md
# Cache Line Byte Extractor

This block turns a full cache line read from the data array into a load result. Every read delivers all 64 bytes of the line together with one even-parity bit per 8-byte bank. The block checks parity over the whole line, rotates the line right by the requested byte offset with a logarithmic barrel shifter, and keeps only as many bytes as the access size asks for. It then zero-extends or sign-extends the value to 64 bits.

An access whose bytes would run past the end of the line is not split. It is flagged as misaligned and returns zero. The result, the parity error flag and the misalignment flag are registered, so they appear one clock after the request. Bytes are little-endian: byte `i` of the line sits on `req_line[8*i+7:8*i]`, and byte 0 of the result is the line byte at the offset.

Top module: `line_extract_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, all outputs become zero on that edge.
- R2: `rsp_valid` is high in the cycle after a cycle with `req_valid` high, and low otherwise. A result appears exactly one clock after its request.
- R3: For an access that fits in the line, byte `k` of `rsp_data` equals line byte `req_offset + k`, for every offset 0 to 63 and for every byte `k` below the access size.
- R4: `req_size` encodes the access width as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes. With `req_signed` low, all result bits above the access width are zero.
- R5: With `req_signed` high, all result bits above the access width are copies of the top bit of the selected field.
- R6: Bank `b` covers line bytes `8b` to `8b+7` and is guarded by `req_par[b]` under even parity, meaning the XOR of the bank's 64 bits and its parity bit must be 0. `rsp_parity_err` is set when any bank that holds a requested byte fails this check.
- R7: A parity failure in a bank that holds none of the requested bytes has no effect on `rsp_parity_err` or `rsp_data`.
- R8: When `req_offset` plus the access width exceeds 64, `rsp_misaligned` is 1, `rsp_data` is 0 and `rsp_parity_err` is 0. Otherwise `rsp_misaligned` is 0.
- R9: A 4-byte unsigned load at offset 20 returns line bytes 20 to 23, which is the sixth 32-bit word of the line (index 5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_line | input | 512 | Full cache line, byte 0 in the low bits |
| req_par | input | 8 | Even-parity bit per 8-byte bank |
| req_offset | input | 6 | Byte offset of the access within the line |
| req_size | input | 2 | Access width code (0:1, 1:2, 2:4, 3:8 bytes) |
| req_signed | input | 1 | 1 = sign-extend, 0 = zero-extend |
| rsp_valid | output | 1 | Result valid |
| rsp_data | output | 64 | Right-justified, extended load value |
| rsp_parity_err | output | 1 | Parity failure in a bank holding requested bytes |
| rsp_misaligned | output | 1 | Access runs past the end of the line |

## Verification
Parity judgement and misalignment can both apply to one request. The bench provokes this by corrupting the parity of the last bank while issuing an access that starts there and runs past byte 63. The expected outcome is the misalignment flag with zero data and no parity error.

A second overlap is an access that straddles two banks with the fault in the second bank, combined with sign extension. The bench checks that the error is raised and that the data is still extracted and extended correctly. A behavioural model built from byte loops predicts every result, and the bench compares it against the outputs on every clock.

// File: rtl/line_extract_pkg.sv
// Shared widths and the access size code for the line extractor.
package line_extract_pkg;
    localparam int LINE_BYTES = 64;
    localparam int BANK_BYTES = 8;
    localparam int DATA_BYTES = 8;
    localparam int LINE_BITS  = LINE_BYTES * 8;
    localparam int DATA_BITS  = DATA_BYTES * 8;
    localparam int NUM_BANKS  = LINE_BYTES / BANK_BYTES;
    localparam int OFF_W      = $clog2(LINE_BYTES);

    // Access width code: number of bytes is 1 << code.
    typedef enum logic [1:0] {
        SZ_B1 = 2'd0,
        SZ_B2 = 2'd1,
        SZ_B4 = 2'd2,
        SZ_B8 = 2'd3
    } acc_size_t;
endpackage

// File: rtl/line_bank_check.sv
// Per-bank even-parity check of the whole line, reduced to one error bit
// over the banks that the access touches (first_bank..last_bank).
// Assumes first_bank <= last_bank whenever the caller uses the result.
module line_bank_check #(
    parameter int LINE_BYTES = 64,
    parameter int BANK_BYTES = 8,
    localparam int NUM_BANKS = LINE_BYTES / BANK_BYTES,
    localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic [LINE_BYTES*8-1:0] line,
    input  logic [NUM_BANKS-1:0]    par,
    input  logic [BANK_W-1:0]       first_bank,
    input  logic [BANK_W-1:0]       last_bank,
    output logic                    err
);
    logic [NUM_BANKS-1:0] bank_bad;
    logic [NUM_BANKS-1:0] bank_used;

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        // One bank: even parity failure and coverage by the access.
        assign bank_bad[b]  = (^line[b*BANK_BYTES*8 +: BANK_BYTES*8]) ^ par[b];
        assign bank_used[b] = (BANK_W'(b) >= first_bank) && (BANK_W'(b) <= last_bank);
    end

    // Reduce the failures to the covered banks only.
    always_comb err = |(bank_bad & bank_used);
endmodule

// File: rtl/line_rotator.sv
// Logarithmic byte rotator: stage s rotates right by 2**s bytes when
// offset bit s is set. The low DATA_BYTES of the rotated line are output.
module line_rotator #(
    parameter int LINE_BYTES = 64,
    parameter int DATA_BYTES = 8,
    localparam int LINE_BITS = LINE_BYTES * 8,
    localparam int OFF_W     = $clog2(LINE_BYTES)
) (
    input  logic [LINE_BITS-1:0]    line,
    input  logic [OFF_W-1:0]        offset,
    output logic [DATA_BYTES*8-1:0] field
);
    logic [LINE_BITS-1:0] stage [0:OFF_W];

    assign stage[0] = line;
    for (genvar s = 0; s < OFF_W; s++) begin : g_stage
        localparam int SH = 8 << s;
        // Conditional rotate right by SH bits.
        assign stage[s+1] = offset[s]
            ? ((stage[s] >> SH) | (stage[s] << (LINE_BITS - SH)))
            : stage[s];
    end

    // Cut to the widest access; narrower sizes are masked later.
    always_comb field = stage[OFF_W][DATA_BYTES*8-1:0];
endmodule

// File: rtl/line_size_extend.sv
// Keeps 1 << size bytes of the rotated field and sign- or zero-extends
// them to the full result width. Assumes DATA_BYTES == 8.
module line_size_extend
    import line_extract_pkg::*;
#(
    parameter int DATA_BYTES = 8,
    localparam int DATA_BITS = DATA_BYTES * 8
) (
    input  logic [DATA_BITS-1:0] field,
    input  acc_size_t            size,
    input  logic                 sign_en,
    output logic [DATA_BITS-1:0] value
);
    logic [DATA_BITS-1:0] keep_mask;
    logic                 top_bit;

    // Select mask and sign bit from the width code.
    always_comb begin
        unique case (size)
            SZ_B1: begin keep_mask = DATA_BITS'({8{1'b1}});  top_bit = field[7];  end
            SZ_B2: begin keep_mask = DATA_BITS'({16{1'b1}}); top_bit = field[15]; end
            SZ_B4: begin keep_mask = DATA_BITS'({32{1'b1}}); top_bit = field[31]; end
            default: begin keep_mask = '1; top_bit = field[DATA_BITS-1]; end
        endcase
    end

    // Apply the mask and fill the upper bits.
    always_comb value = (field & keep_mask) | ((sign_en && top_bit) ? ~keep_mask : '0);
endmodule

// File: rtl/line_extract_top.sv
// Load-path extractor: parity check of the full line, byte rotation by the
// offset, size cut and extension, and line-overrun detection, with one
// output register stage. Assumes the line arrives in byte order.
module line_extract_top
    import line_extract_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [LINE_BITS-1:0]  req_line,
    input  logic [NUM_BANKS-1:0]  req_par,
    input  logic [OFF_W-1:0]      req_offset,
    input  logic [1:0]            req_size,
    input  logic                  req_signed,
    output logic                  rsp_valid,
    output logic [DATA_BITS-1:0]  rsp_data,
    output logic                  rsp_parity_err,
    output logic                  rsp_misaligned
);
    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int END_W  = OFF_W + 1;
    localparam int BSH    = $clog2(BANK_BYTES);

    acc_size_t            size_code;
    logic [END_W-1:0]     end_pos;
    logic                 overrun;
    logic [BANK_W-1:0]    first_bank;
    logic [BANK_W-1:0]    last_bank;
    logic                 par_err;
    logic [DATA_BITS-1:0] field;
    logic [DATA_BITS-1:0] ext_value;
    logic [7:0]           lead_byte;

    // Decode the access extent: one past its last byte and the banks it spans.
    always_comb begin
        size_code  = acc_size_t'(req_size);
        end_pos    = END_W'(req_offset) + (END_W'(1) << req_size);
        overrun    = end_pos > END_W'(LINE_BYTES);
        first_bank = req_offset[OFF_W-1:BSH];
        last_bank  = BANK_W'((end_pos - END_W'(1)) >> BSH);
    end

    line_bank_check #(.LINE_BYTES(LINE_BYTES), .BANK_BYTES(BANK_BYTES)) u_check (
        .line(req_line), .par(req_par),
        .first_bank(first_bank), .last_bank(last_bank), .err(par_err)
    );

    line_rotator #(.LINE_BYTES(LINE_BYTES), .DATA_BYTES(DATA_BYTES)) u_rot (
        .line(req_line), .offset(req_offset), .field(field)
    );

    line_size_extend #(.DATA_BYTES(DATA_BYTES)) u_ext (
        .field(field), .size(size_code), .sign_en(req_signed), .value(ext_value)
    );

    // Result register: capture on a request, zero on overrun.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid      <= 1'b0;
            rsp_data       <= '0;
            rsp_parity_err <= 1'b0;
            rsp_misaligned <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_misaligned <= overrun;
                rsp_data       <= overrun ? '0 : ext_value;
                rsp_parity_err <= overrun ? 1'b0 : par_err;
            end
        end
    end

    // Byte at the offset, taken directly from the line for the checks below.
    always_comb lead_byte = req_line[{req_offset, 3'b000} +: 8];

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    assert_lead_byte_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !overrun) |=> (rsp_data[7:0] == $past(lead_byte)));
    assert_zero_ext_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_signed && req_size == 2'd0) |=> (rsp_data[63:8] == '0));
    assert_sign_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_signed && req_size == 2'd0 && !overrun)
        |=> (rsp_data[63:8] == {56{rsp_data[7]}}));
    assert_overrun_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && overrun)
        |=> (rsp_misaligned && rsp_data == '0 && !rsp_parity_err));
endmodule

// File: tb/line_extract_top_tb.sv
module line_extract_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         req_valid;
    logic [511:0] req_line;
    logic [7:0]   req_par;
    logic [5:0]   req_offset;
    logic [1:0]   req_size;
    logic         req_signed;
    logic         rsp_valid;
    logic [63:0]  rsp_data;
    logic         rsp_parity_err;
    logic         rsp_misaligned;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    line_extract_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line(req_line),
        .req_par(req_par), .req_offset(req_offset), .req_size(req_size),
        .req_signed(req_signed), .rsp_valid(rsp_valid), .rsp_data(rsp_data),
        .rsp_parity_err(rsp_parity_err), .rsp_misaligned(rsp_misaligned)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] good_par(input logic [511:0] ln);
        logic [7:0] p;
        for (int b = 0; b < 8; b++) p[b] = ^ln[b*64 +: 64];
        return p;
    endfunction

    // Behavioural model: one request in, outputs checked at the next negedge.
    task automatic access(input logic [511:0] ln, input logic [7:0] par,
                          input int off, input int sz, input bit sgn);
        int nb;
        logic [63:0] ev;
        logic ee, em;
        nb = 1 << sz;
        ev = '0; ee = 1'b0; em = 1'b0;
        if (off + nb > 64) begin
            em = 1'b1;
        end else begin
            for (int i = 0; i < nb; i++) ev[i*8 +: 8] = ln[(off+i)*8 +: 8];
            if (sgn && ev[nb*8-1])
                for (int i = nb*8; i < 64; i++) ev[i] = 1'b1;
            for (int b = off/8; b <= (off+nb-1)/8; b++)
                if ((^ln[b*64 +: 64]) ^ par[b]) ee = 1'b1;
        end
        req_valid = 1'b1; req_line = ln; req_par = par;
        req_offset = 6'(off); req_size = 2'(sz); req_signed = sgn;
        @(negedge clk);
        check("R2 valid", {63'd0, rsp_valid}, 64'd1);
        check("R3/R4/R5 data", rsp_data, ev);
        check("R6/R7 parity_err", {63'd0, rsp_parity_err}, {63'd0, ee});
        check("R8 misaligned", {63'd0, rsp_misaligned}, {63'd0, em});
    endtask

    function automatic logic [511:0] rnd_line();
        logic [511:0] l;
        for (int w = 0; w < 16; w++) l[w*32 +: 32] = $urandom;
        return l;
    endfunction

    initial begin : watchdog
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [511:0] ln;
        logic [7:0]   p;
        rst_n = 1'b0; req_valid = 1'b0; req_line = '0; req_par = '0;
        req_offset = '0; req_size = '0; req_signed = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 valid", {63'd0, rsp_valid}, 64'd0);
        check("R1 data", rsp_data, 64'd0);
        check("R1 err", {62'd0, rsp_parity_err, rsp_misaligned}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle", {63'd0, rsp_valid}, 64'd0);

        // R9: int array, element 5 at offset 20
        for (int i = 0; i < 16; i++) ln[i*32 +: 32] = 32'h1000_0000 + i;
        access(ln, good_par(ln), 20, 2, 1'b0);
        check("R9 word5", rsp_data, 64'h0000_0000_1000_0005);

        // R3: every offset, byte loads
        ln = rnd_line();
        for (int o = 0; o < 64; o++) access(ln, good_par(ln), o, 0, 1'b0);
        // R4/R5: every size, both extensions, negative values
        for (int i = 0; i < 64; i++) ln[i*8 +: 8] = 8'h80 | 8'(i);
        for (int s = 0; s < 4; s++) begin
            access(ln, good_par(ln), 8, s, 1'b0);
            access(ln, good_par(ln), 8, s, 1'b1);
        end
        // R6: bank-straddling signed access, fault in the second bank
        ln = rnd_line(); p = good_par(ln); p[2] = ~p[2];
        access(ln, p, 14, 2, 1'b1);
        check("R6 straddle err", {63'd0, rsp_parity_err}, 64'd1);
        // R7: fault in an untouched bank
        p = good_par(ln); p[7] = ~p[7];
        access(ln, p, 0, 3, 1'b0);
        check("R7 ignored", {63'd0, rsp_parity_err}, 64'd0);
        // R8 with parity fault in the same request
        access(ln, p, 60, 3, 1'b1);
        check("R8 overrun", {62'd0, rsp_misaligned, rsp_parity_err}, 64'd2);
        access(ln, p, 56, 3, 1'b0);
        check("R8 exact end", {63'd0, rsp_misaligned}, 64'd0);
        access(ln, p, 63, 1, 1'b0);

        // Random mix with occasional faults and idle gaps
        for (int n = 0; n < 400; n++) begin
            ln = rnd_line(); p = good_par(ln);
            if ($urandom_range(3) == 0) p[$urandom_range(7)] ^= 1'b1;
            access(ln, p, $urandom_range(63), $urandom_range(3), 1'($urandom_range(1)));
            if ($urandom_range(4) == 0) begin
                req_valid = 1'b0;
                @(negedge clk);
                check("R2 gap", {63'd0, rsp_valid}, 64'd0);
            end
        end
        req_valid = 1'b0;
        @(negedge clk);
        check("R2 end", {63'd0, rsp_valid}, 64'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule